// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Alarm Unit

This block is the event section of a PC-style real-time clock. A separate time counter supplies the current second, minute, hour, day and month bytes. It also supplies a one-cycle tick after each increment of the seconds. The block watches those bytes against a set of alarm registers. It also divides a 32.768 kHz reference strobe down to a programmable periodic event. Three event flags (periodic, alarm, update) latch into a status byte whether or not software has enabled them. Only the summary bit and the interrupt pin are gated by the enables.

Software reaches the block through a narrow register port: a 3-bit address, a write strobe, a read strobe and byte-wide data. Reading the status byte hands back the flags and clears them in the same access. Alarm fields accept a "don't care" code, so one alarm can fire every second, every minute or once a day. The optional date fields widen the reach to a month or a year. Values are compared as raw codes, so the same hardware serves BCD and binary time formats.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset the rate register reads 0x06, the control register reads 0x00, the status register reads 0x00, the alarm registers read 0x00, and irqOut is low.
- R2: Address 0 holds a 4-bit rate select in bits 3:0, with the upper bits reading 0. Address 1 is the control byte: bit 6 enables the periodic interrupt, bit 5 the alarm interrupt, bit 4 the update interrupt, bit 2 selects the data format and bit 1 the 24-hour mode. Its other bits read 0. Addresses 3 to 7 hold the second, minute, hour, day and month alarm bytes in full.
- R3: Address 2 is the status byte: bit 7 summary, bit 6 periodic flag, bit 5 alarm flag, bit 4 update flag, bits 3:0 zero. Writes to it have no effect.
- R4: Each flag latches when its event occurs, whatever its enable. The summary bit and irqOut are high exactly when some flag is set and the control bit at the same position is set. They change in the cycle after the register edge that changes a flag or an enable.
- R5: A read of address 2 returns the status before the access and clears all flags at that edge. An event in the same cycle as that read still leaves its flag set.
- R6: Every secTick pulse sets the update flag.
- R7: On a secTick pulse the alarm flag sets when the second, minute and hour fields all match. A field matches when the alarm byte equals the time byte, or when the alarm byte has both bits 7 and 6 set.
- R8: With the date option on (default), the day alarm compares only bits 5:0 with bits 5:0 of the day. It is ignored when those bits are 0 or when its bits 7:6 are both set. The month alarm must also match under the rule of R7.
- R9: A free-running count of refTick pulses sets the periodic flag on each pulse whose 0-based count modulo P equals P-1. P is 128 for rate 1, 256 for rate 2, and 2^(rate-1) for rates 3 to 15. Rate 0 disables the periodic flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (clears status when address is 2) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register (combinational) |
| refTick | input | 1 | One-cycle pulse at 32.768 kHz |
| secTick | input | 1 | One-cycle pulse after each seconds increment |
| timeSec | input | 8 | Current seconds code |
| timeMin | input | 8 | Current minutes code |
| timeHour | input | 8 | Current hours code (24-hour) |
| timeDay | input | 8 | Current day-of-month code |
| timeMon | input | 8 | Current month code |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that regWr and regRd are never high in the same cycle. They also assume the time bytes are stable in any cycle where secTick is high, so the compare sees one time value. The stimulus drives at most one register operation per cycle. The random phase picks either a read or a write, never both. The time bytes change only between cycles, and the model samples them in the same cycle as the tick. Rate changes land at arbitrary counter phases, and the periodic assertion only claims spacing while the rate stays unchanged.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int RATE_W = 4;
  localparam int ALM_N = 5;
  localparam int ALM_BASE_N = 3;

  localparam logic [ADDR_W-1:0] ADR_RATE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_ASEC = 3'd3;

  localparam int ALM_SEC = 0;
  localparam int ALM_MIN = 1;
  localparam int ALM_HOUR = 2;
  localparam int ALM_DAY = 3;
  localparam int ALM_MON = 4;

  localparam int BIT_IRQF = 7;
  localparam int BIT_PF = 6;
  localparam int BIT_AF = 5;
  localparam int BIT_UF = 4;

  // one mask for both the status flags and their enables
  localparam logic [DATA_W-1:0] EVT_MASK = 8'h70;
  localparam logic [DATA_W-1:0] CTRL_WMASK = 8'h76;
  localparam logic [DATA_W-1:0] DAY_MASK = 8'h3F;
  localparam logic [RATE_W-1:0] RATE_RST = 4'd6;

  typedef struct packed {
    logic wrRate;
    logic wrCtrl;
    logic [ALM_N-1:0] wrAlm;
    logic clrFlags;
    logic perEvt;
    logic secEvt;
  } strobe_t;

  function automatic logic fieldHit(logic [DATA_W-1:0] alm, logic [DATA_W-1:0] cur);
    return (alm[DATA_W-1:DATA_W-2] == 2'b11) || (alm == cur);
  endfunction
endpackage

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int PRESC_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              refTick,
  input  logic              secTick,
  input  logic [RATE_W-1:0] rateSel,
  output strobe_t           strb
);
  logic [PRESC_W-1:0] preCnt;
  logic [RATE_W-1:0] shiftAmt;
  logic [PRESC_W-1:0] lowMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (refTick) preCnt <= preCnt + PRESC_W'(1);
  end

  always_comb begin
    case (rateSel)
      4'd0: shiftAmt = 4'd0;
      4'd1: shiftAmt = 4'd7;
      4'd2: shiftAmt = 4'd8;
      default: shiftAmt = rateSel - 4'd1;
    endcase
    lowMask = (PRESC_W'(1) << shiftAmt) - PRESC_W'(1);
  end

  always_comb begin
    strb.wrRate = regWr && (regAddr == ADR_RATE);
    strb.wrCtrl = regWr && (regAddr == ADR_CTRL);
    for (int i = 0; i < ALM_N; i++)
      strb.wrAlm[i] = regWr && (regAddr == ADR_ASEC + ADDR_W'(i));
    strb.clrFlags = regRd && (regAddr == ADR_FLAG);
    strb.perEvt = refTick && (rateSel != '0) && ((preCnt & lowMask) == lowMask);
    strb.secEvt = secTick;
  end

  // R9: every nonzero rate spans at least four reference ticks
  assert_period_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.perEvt |=> (!strb.perEvt || (rateSel != $past(rateSel))));
endmodule

// File: rtl/rtc_irq_dp.sv
module rtc_irq_dp
  import rtc_irq_pkg::*;
#(
  parameter bit HAS_DATE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] timeSec,
  input  logic [DATA_W-1:0] timeMin,
  input  logic [DATA_W-1:0] timeHour,
  input  logic [DATA_W-1:0] timeDay,
  input  logic [DATA_W-1:0] timeMon,
  output logic [RATE_W-1:0] rateSel,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [RATE_W-1:0] rateReg;
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] flagReg;
  logic [DATA_W-1:0] almReg [ALM_N];
  logic [DATA_W-1:0] setVec;
  logic dayOk, monOk, almHit, irqf;

  for (genvar g = 0; g < ALM_N; g++) begin : gAlm
    if (g < ALM_BASE_N || HAS_DATE) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) almReg[g] <= '0;
        else if (strb.wrAlm[g]) almReg[g] <= wrData;
      end
    end else begin : gNone
      assign almReg[g] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateReg <= RATE_RST;
      ctrlReg <= '0;
    end else begin
      if (strb.wrRate) rateReg <= wrData[RATE_W-1:0];
      if (strb.wrCtrl) ctrlReg <= wrData & CTRL_WMASK;
    end
  end

  always_comb begin
    dayOk = (HAS_DATE == 1'b0) || (almReg[ALM_DAY][DATA_W-1:DATA_W-2] == 2'b11)
         || ((almReg[ALM_DAY] & DAY_MASK) == '0)
         || ((almReg[ALM_DAY] & DAY_MASK) == (timeDay & DAY_MASK));
    monOk = (HAS_DATE == 1'b0) || fieldHit(almReg[ALM_MON], timeMon);
    almHit = fieldHit(almReg[ALM_SEC], timeSec) && fieldHit(almReg[ALM_MIN], timeMin)
          && fieldHit(almReg[ALM_HOUR], timeHour) && dayOk && monOk;
    setVec = '0;
    setVec[BIT_PF] = strb.perEvt;
    setVec[BIT_AF] = strb.secEvt && almHit;
    setVec[BIT_UF] = strb.secEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagReg <= '0;
    else flagReg <= (strb.clrFlags ? '0 : flagReg) | setVec;
  end

  assign irqf = |(flagReg & ctrlReg & EVT_MASK);
  assign irqOut = irqf;
  assign rateSel = rateReg;

  always_comb begin
    case (regAddr)
      ADR_RATE: rdData = DATA_W'(rateReg);
      ADR_CTRL: rdData = ctrlReg;
      ADR_FLAG: begin
        rdData = flagReg;
        rdData[BIT_IRQF] = irqf;
      end
      default: rdData = almReg[regAddr - ADR_ASEC];
    endcase
  end

  // R4: without an event or a control write the request cannot appear
  assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !strb.wrCtrl && !strb.perEvt && !strb.secEvt) |=> !irqOut);
  // R4: a latched flag only drops through a status read
  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrFlags |=> (($past(flagReg) & ~flagReg) == '0));
  // R5: a status read with no event leaves every flag clear
  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlags && !strb.perEvt && !strb.secEvt) |=> (flagReg == '0));
  // R6: a seconds tick always leaves the update flag set
  assert_update_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.secEvt |=> flagReg[BIT_UF]);
  // R9: a periodic event always leaves the periodic flag set
  assert_periodic_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.perEvt |=> flagReg[BIT_PF]);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter bit HAS_DATE = 1'b1,
  parameter int PRESC_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              refTick,
  input  logic              secTick,
  input  logic [DATA_W-1:0] timeSec,
  input  logic [DATA_W-1:0] timeMin,
  input  logic [DATA_W-1:0] timeHour,
  input  logic [DATA_W-1:0] timeDay,
  input  logic [DATA_W-1:0] timeMon,
  output logic              irqOut
);
  strobe_t strb;
  logic [RATE_W-1:0] rateSel;

  rtc_irq_ctrl #(.PRESC_W(PRESC_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .refTick(refTick), .secTick(secTick), .rateSel(rateSel), .strb(strb)
  );

  rtc_irq_dp #(.HAS_DATE(HAS_DATE)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .wrData(wrData),
    .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour),
    .timeDay(timeDay), .timeMon(timeMon),
    .rateSel(rateSel), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/test_rtc_irq_unit.sv
module test_rtc_irq_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0, refTick = 1'b0, secTick = 1'b0;
  logic [7:0] wrData = '0, rdData;
  logic [7:0] timeSec = '0, timeMin = '0, timeHour = '0, timeDay = 8'h01, timeMon = 8'h01;
  logic irqOut;

  int checks = 0, errors = 0;
  bit done = 0;
  int mRate, mCtrl, mFlag, refCnt;
  int mAlm [5];

  always #2 clk = ~clk;

  rtc_irq_unit i_rtc_irq_unit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .wrData(wrData), .rdData(rdData), .refTick(refTick), .secTick(secTick),
    .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour),
    .timeDay(timeDay), .timeMon(timeMon), .irqOut(irqOut)
  );

  function automatic int periodOf(int rs);
    if (rs == 0) return 0;
    if (rs == 1) return 128;
    if (rs == 2) return 256;
    return 1 << (rs - 1);
  endfunction

  function automatic bit hit(int a, int c);
    return ((a >> 6) == 3) || (a == c);
  endfunction

  function automatic bit expIrq();
    return (mFlag & mCtrl & 'h70) != 0;
  endfunction

  function automatic int expRd(int a);
    case (a)
      0: return mRate;
      1: return mCtrl;
      2: return mFlag | (expIrq() ? 'h80 : 0);
      default: return mAlm[a - 3];
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive, compare against model state, advance model
  task automatic cyc(bit wr, bit rd, int a, int d, bit rt, bit st, string tag);
    bit pe, ae, dOk;
    int p;
    regWr = wr; regRd = rd; regAddr = 3'(a); wrData = 8'(d);
    refTick = rt; secTick = st;
    #1;
    chk("R4 irqOut", int'(irqOut), int'(expIrq()));
    if (rd) chk(tag, int'(rdData), expRd(a));
    p = periodOf(mRate);
    pe = rt && (p != 0) && ((refCnt % p) == p - 1);
    if (rt) refCnt = (refCnt + 1) % 32768;
    dOk = ((mAlm[3] >> 6) == 3) || ((mAlm[3] & 'h3F) == 0) || ((mAlm[3] & 'h3F) == (timeDay & 'h3F));
    ae = st && hit(mAlm[0], timeSec) && hit(mAlm[1], timeMin) && hit(mAlm[2], timeHour)
         && dOk && hit(mAlm[4], timeMon);
    if (rd && a == 2) mFlag = 0;
    if (pe) mFlag |= 'h40;
    if (ae) mFlag |= 'h20;
    if (st) mFlag |= 'h10;
    if (wr) begin
      if (a == 0) mRate = d & 'hF;
      else if (a == 1) mCtrl = d & 'h76;
      else if (a >= 3) mAlm[a - 3] = d & 'hFF;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(int a, int d); cyc(1, 0, a, d, 0, 0, ""); endtask
  task automatic rdReg(int a, string tag); cyc(0, 1, a, 0, 0, 0, tag); endtask
  task automatic run(int n, bit rt, bit st);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, rt, st, "");
  endtask
  task automatic setTime(int s, int m, int h, int dd, int mm);
    timeSec = 8'(s); timeMin = 8'(m); timeHour = 8'(h); timeDay = 8'(dd); timeMon = 8'(mm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mRate = 6; mCtrl = 0; mFlag = 0; refCnt = 0;
    for (int i = 0; i < 5; i++) mAlm[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values of every register
    for (int a = 0; a < 8; a++) rdReg(a, "R1 reset value");

    // R2: write masks and readback
    wrReg(1, 'hFF); rdReg(1, "R2 control mask");
    wrReg(0, 'hF3); rdReg(0, "R2 rate field");
    for (int a = 3; a < 8; a++) begin
      wrReg(a, 'h11 * a); rdReg(a, "R2 alarm readback");
    end
    // R3: status byte is read-only
    wrReg(2, 'hFF); rdReg(2, "R3 status write ignored");
    wrReg(1, 'h00);
    rdReg(2, "R5 clear");

    // R4/R9: periodic flag latches while disabled, rate 3 -> every 4 ticks
    run(10, 1, 0);
    rdReg(2, "R4 flag latched while disabled");
    rdReg(2, "R5 cleared after read");
    wrReg(1, 'h40);
    run(9, 1, 0);
    rdReg(2, "R4 summary with enable");
    // R9: rate 0 disables, rate 1 gives 128-tick period
    wrReg(0, 0); rdReg(2, "R5 clear"); run(40, 1, 0); rdReg(2, "R9 rate zero off");
    wrReg(0, 1); run(300, 1, 0); rdReg(2, "R9 rate one");
    wrReg(0, 15); run(100, 1, 0); rdReg(2, "R9 rate fifteen");
    wrReg(1, 'h30); rdReg(2, "R5 clear");

    // R6/R7: alarm on exact match
    wrReg(3, 'h30); wrReg(4, 'h15); wrReg(5, 'h08); wrReg(6, 'hC0); wrReg(7, 'hFF);
    setTime('h30, 'h15, 'h08, 'h05, 'h06);
    run(1, 0, 1); rdReg(2, "R7 alarm match");
    setTime('h30, 'h16, 'h08, 'h05, 'h06);
    run(1, 0, 1); rdReg(2, "R7 minute mismatch");
    wrReg(4, 'hC5);
    run(1, 0, 1); rdReg(2, "R7 wildcard minute");
    // R8: day compare on low six bits, zero means unset, month compared
    wrReg(6, 'h45); run(1, 0, 1); rdReg(2, "R8 day low bits match");
    wrReg(6, 'h12); run(1, 0, 1); rdReg(2, "R8 day mismatch");
    wrReg(6, 'h00); run(1, 0, 1); rdReg(2, "R8 day unset");
    wrReg(7, 'h07); run(1, 0, 1); rdReg(2, "R8 month mismatch");
    wrReg(7, 'h06); run(1, 0, 1); rdReg(2, "R8 month match");
    // R5: event in the same cycle as the status read survives
    cyc(0, 1, 2, 0, 0, 1, "R5 read with event");
    rdReg(2, "R5 event kept");
    // R6: update flag with enable, alarm disabled by mismatch
    wrReg(1, 'h10); wrReg(3, 'h00); run(1, 0, 1); rdReg(2, "R6 update flag");

    // mixed random traffic compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      int op, a, d;
      op = $urandom_range(0, 9);
      a = $urandom_range(0, 7);
      case ($urandom_range(0, 3))
        0: d = 'hFF;
        1: d = 'hC0 | $urandom_range(0, 3);
        default: d = $urandom_range(0, 3);
      endcase
      if (a == 0) d = $urandom_range(0, 5);
      if (a == 1) d = $urandom_range(0, 255);
      if (a == 6 && $urandom_range(0, 1) == 1) d = 'h40 | $urandom_range(0, 3);
      if ($urandom_range(0, 7) == 0)
        setTime($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3));
      cyc(op == 0, op == 1 || op == 2, (op == 2) ? 2 : a, d,
          $urandom_range(0, 1) == 1, $urandom_range(0, 15) == 0,
          ((op == 2) || a == 2) ? "R5 random status" : "R2 random readback");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule